// File: doc/BRIEF.md
# Completion Filter and Status Injector

This block sits on the receive path that carries packets from the link back up to the host-side control stream. A packet replayer elsewhere runs a transmit loop. While that loop runs with readout turned off, every completion packet that comes back is consumed and thrown away, so read responses cannot flood the host path. At every other time, completions pass through unchanged. Packets that are not completions always pass through.

The block also places all-ones 128-bit status packets into the upward stream. The first throttle event of a loop causes one status packet. If the loop then runs on to its natural end, because halt-on-throttle is off, the done pulse causes a second status packet. If no throttle event occurred, the loop ends without any status packet. Status requests are counted in a small saturating queue. Each one is kept until the host side accepts it.

Both streams use valid/ready handshaking. A beat moves when valid and ready are both high on a clock edge. The input side is ready whenever the current beat is to be dropped. Otherwise it is ready only when no status is pending and the output is ready. A forwarded beat is therefore held back by backpressure, never lost. A pending status packet keeps the output valid until it is accepted.

Top module: `cpl_status_filter`

## Requirements
- R1: An input beat is a completion when `rx_data_i[28:24]` equals 5'b01010; any other value marks a non-completion, which is never dropped.
- R2: A valid completion that arrives while `loop_active_i`=1 and `readout_en_i`=0 is consumed (`rx_ready_o`=1) and does not appear on the output.
- R3: A valid completion that arrives while the loop is inactive or readout is enabled is forwarded with unchanged data.
- R4: The first `throttle_pulse_i` seen while the loop is active queues one all-ones status packet. Further throttle pulses queue nothing until the next `done_pulse_i`.
- R5: A `done_pulse_i` that follows a queued throttle status, with `halt_on_throttle_i`=0, queues a second all-ones status packet.
- R6: With `halt_on_throttle_i`=1 at the done pulse, a done after a throttle queues nothing.
- R7: A done pulse with no throttle since the previous done queues nothing.
- R8: While any status is pending, `tx_valid_o`=1, `tx_data_o` is all ones and a forwardable input beat is held (`rx_ready_o`=0).
- R9: Pending status packets are kept under output backpressure, up to 7 at once (the queue saturates there), and each one is delivered as a separate accepted beat.
- R10: After reset no status is pending, and with no input the output is idle.
- R11: A throttle pulse while the loop is inactive is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_active_i | input | 1 | Replayer loop is running |
| readout_en_i | input | 1 | Forward completions during the loop |
| halt_on_throttle_i | input | 1 | Loop stops at first throttle |
| throttle_pulse_i | input | 1 | One-cycle throttle event |
| done_pulse_i | input | 1 | One-cycle loop-finished event |
| rx_valid_i | input | 1 | Input beat valid |
| rx_ready_o | output | 1 | Input beat accepted or consumed |
| rx_data_i | input | 128 | Input beat |
| tx_valid_o | output | 1 | Output beat valid |
| tx_ready_i | input | 1 | Host side accepts beat |
| tx_data_o | output | 128 | Output beat |

## Verification
A status packet and a forwardable input beat can both claim the output in the same cycle. The same can happen when a throttle event or done pulse coincides with the acceptance of an earlier status packet. The bench provokes these clashes with directed sequences that stall the output while completions and non-completions keep arriving. Random traffic, throttle pulses and done pulses then overlap freely. Every cycle, a bench model of the pending count predicts output valid, output data and input ready. The design is judged against that prediction, so a held beat must reappear intact once the status packets have drained.

// File: rtl/cpl_status_pkg.sv
package cpl_status_pkg;
  localparam int TYPE_W = 5;
  localparam logic [TYPE_W-1:0] CPL_TYPE = 5'b01010;
endpackage

// File: rtl/cpl_classifier.sv
module cpl_classifier #(
  parameter int DATA_W   = 128,
  parameter int TYPE_LSB = 24
) (
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              loop_active_i,
  input  logic              readout_en_i,
  output logic              drop_o
);
  import cpl_status_pkg::*;
  logic is_cpl;
  always_comb begin
    is_cpl = (rx_data_i[TYPE_LSB +: TYPE_W] == CPL_TYPE);
    drop_o = rx_valid_i && is_cpl && loop_active_i && !readout_en_i;
  end
endmodule

// File: rtl/status_tracker.sv
module status_tracker #(
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_active_i,
  input  logic              halt_on_throttle_i,
  input  logic              throttle_pulse_i,
  input  logic              done_pulse_i,
  input  logic              pop_i,
  output logic              pending_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  logic [PEND_W-1:0] pend_q, pend_n;
  logic seen_q;
  logic ev_thr, ev_done;
  logic [PEND_W:0] sum;

  always_comb begin
    ev_thr  = throttle_pulse_i && loop_active_i && !seen_q;
    ev_done = done_pulse_i && seen_q && !halt_on_throttle_i;
    sum = {1'b0, pend_q} + PEND_W'(ev_thr) + PEND_W'(ev_done) - (PEND_W+1)'(pop_i);
    if (sum > {1'b0, PEND_MAX}) pend_n = PEND_MAX;
    else                        pend_n = sum[PEND_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      seen_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      if (done_pulse_i)  seen_q <= 1'b0;
      else if (ev_thr)   seen_q <= 1'b1;
    end
  end

  assign pending_o = (pend_q != '0);

  // R9
  pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !pop_i) |=> pending_o);
  // R7
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse_i && !seen_q && !throttle_pulse_i && !pending_o) |=> !pending_o);
endmodule

// File: rtl/out_arbiter.sv
module out_arbiter #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending_i,
  input  logic              drop_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  output logic              pop_o
);
  always_comb begin
    tx_valid_o = pending_i || (rx_valid_i && !drop_i);
    tx_data_o  = pending_i ? '1 : rx_data_i;
    rx_ready_o = drop_i || (!pending_i && tx_ready_i);
    pop_o      = pending_i && tx_ready_i;
  end

  // R8
  status_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_i && !tx_ready_i) |=> (tx_valid_o && (&tx_data_o)));
endmodule

// File: rtl/cpl_status_filter.sv
module cpl_status_filter #(
  parameter int DATA_W   = 128,
  parameter int TYPE_LSB = 24,
  parameter int PEND_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_active_i,
  input  logic              readout_en_i,
  input  logic              halt_on_throttle_i,
  input  logic              throttle_pulse_i,
  input  logic              done_pulse_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o
);
  logic drop, pending, pop;

  cpl_classifier #(.DATA_W(DATA_W), .TYPE_LSB(TYPE_LSB)) u_cls (
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .loop_active_i(loop_active_i), .readout_en_i(readout_en_i),
    .drop_o(drop));

  status_tracker #(.PEND_W(PEND_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .loop_active_i(loop_active_i),
    .halt_on_throttle_i(halt_on_throttle_i), .throttle_pulse_i(throttle_pulse_i),
    .done_pulse_i(done_pulse_i), .pop_i(pop), .pending_o(pending));

  out_arbiter #(.DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .pending_i(pending), .drop_i(drop),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
    .pop_o(pop));

  // R2
  drop_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> rx_ready_o);
  // R8
  status_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> tx_valid_o);
  // R3
  fwd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !pending) |-> (tx_data_o == rx_data_i && rx_valid_i && !drop));
endmodule

// File: tb/cpl_status_filter_tb.sv
module cpl_status_filter_tb;
  localparam int DW = 128;
  localparam int PMAX = 7;
  logic clk = 0, rst_n = 0;
  logic loop_a = 0, rdout = 0, halt = 0, thr = 0, done = 0, rxv = 0, txr = 0;
  logic [DW-1:0] rxd = '0;
  logic rxr, txv;
  logic [DW-1:0] txd;
  int checks = 0, errors = 0;
  int m_pend = 0;
  bit m_seen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cpl_status_filter u_dut (
    .clk(clk), .rst_n(rst_n), .loop_active_i(loop_a), .readout_en_i(rdout),
    .halt_on_throttle_i(halt), .throttle_pulse_i(thr), .done_pulse_i(done),
    .rx_valid_i(rxv), .rx_ready_o(rxr), .rx_data_i(rxd),
    .tx_valid_o(txv), .tx_ready_i(txr), .tx_data_o(txd));

  function automatic bit is_cpl(logic [DW-1:0] d);
    return d[28:24] == 5'b01010;
  endfunction

  function automatic logic [DW-1:0] mk(bit cpl);
    logic [DW-1:0] d;
    d = {$urandom, $urandom, $urandom, $urandom};
    if (cpl) d[28:24] = 5'b01010;
    else if (d[28:24] == 5'b01010) d[24] = 1'b1;
    return d;
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    bit drop, ev_thr, ev_done, pop, ev, exv;
    string t;
    #1;
    drop = rxv && is_cpl(rxd) && loop_a && !rdout;
    exv = (m_pend != 0) || (rxv && !drop);
    t = tag;
    if (t == "") t = (m_pend != 0) ? "R8" : (drop ? "R2" : "R3");
    chk(t, "tx_valid", DW'(txv), DW'(exv));
    chk(t, "rx_ready", DW'(rxr), DW'(drop || (m_pend == 0 && txr)));
    if (exv) chk(t, "tx_data", txd, (m_pend != 0) ? '1 : rxd);
    ev_thr = thr && loop_a && !m_seen;
    ev_done = done && m_seen && !halt;
    pop = (m_pend != 0) && txr;
    @(posedge clk);
    m_pend = m_pend + int'(ev_thr) + int'(ev_done) - int'(pop);
    if (m_pend > PMAX) m_pend = PMAX;
    if (done) m_seen = 0; else if (ev_thr) m_seen = 1;
    @(negedge clk);
    thr = 0; done = 0;
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    step("R10");
    // R1/R2: completion dropped in loop, non-completion forwarded
    loop_a = 1; txr = 1; rxv = 1; rxd = mk(1); step("R2");
    rxd = mk(0); step("R1");
    // R3: readout on, then loop off
    rdout = 1; rxd = mk(1); step("R3");
    rdout = 0; loop_a = 0; rxd = mk(1); step("R3");
    // R11: throttle outside loop
    rxv = 0; thr = 1; step("R11"); step("R11");
    // R4/R8/R9/R5: stalled output, repeated throttles, done
    loop_a = 1; txr = 0; thr = 1; step("R4");
    thr = 1; step("R4");
    rxv = 1; rxd = mk(0); step("R8"); step("R8");
    done = 1; step("R5");
    step("R9");
    txr = 1; step("R9"); step("R9"); step("R9");
    // R6: halt mode
    rxv = 0; halt = 1; thr = 1; step("R6");
    done = 1; step("R6"); step("R6"); step("R6");
    halt = 0;
    // R7: done without throttle
    done = 1; step("R7"); step("R7");
    // R9: saturation of the queue
    txr = 0;
    for (int i = 0; i < 10; i++) begin thr = 1; step("R9"); done = 1; step("R9"); end
    txr = 1;
    for (int i = 0; i < 9; i++) step("R9");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 40) == 0) loop_a = ~loop_a;
      if ($urandom_range(0, 60) == 0) rdout = ~rdout;
      if ($urandom_range(0, 80) == 0) halt = ~halt;
      thr = ($urandom_range(0, 19) == 0);
      done = ($urandom_range(0, 29) == 0);
      txr = ($urandom_range(0, 3) != 0);
      if (!rxv || rxr) begin
        rxv = $urandom_range(0, 1);
        rxd = mk($urandom_range(0, 1));
      end
      step("");
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule